// File: doc/BRIEF.md
# Multi-slot interrupt combiner

This block merges the interrupt requests of several plug-in module slots into a single host interrupt line. Each slot drives two request lines. A per-slot control byte sets, for each of its two lines, whether requests are accepted and whether the line is treated as edge- or level-sensitive. The accepted state of every line is held in a status word. Lines in level mode combine into a held output level. Lines in edge mode produce a one-cycle inversion of that level.

The host reaches the block through a simple register port. It can write and read the control bytes, read the status word, and clear sticky per-slot timeout flags. Reading a line's acknowledge location sends a one-cycle lower-request pulse back to that line's slot. A transition on a request line is taken at the next rising clock edge. The status word and the host line change at that same edge, and only when the status word actually changes.

Top module: `slot_irq_combiner`

## Requirements
- R1: After reset, `irq_o` is 0, every control byte reads 0, the status word reads 0 and `ack_o` is 0.
- R2: A write to address s (0 to 3) stores `reg_wdata[7:0]` as the control byte of slot s, and reading address s returns that byte in bits 7:0 with zeros above. Control bit 0 enables line 0, bit 1 enables line 1, bit 2 selects edge mode for line 0 and bit 3 selects edge mode for line 1. Edge mode applies when the bit is 1 and level mode when it is 0.
- R3: A transition on request line 2*s+n while the enable bit for that line is 0 leaves the status word and `irq_o` unchanged.
- R4: When a request line is enabled, a rising or falling transition on `req_i[2*s+n]` sets or clears status bit 2*s+n at the next rising clock edge.
- R5: When the status word changes, the held level becomes 1 if any status bit of a level-mode line is set, and becomes 0 otherwise. Without a pulse, `irq_o` equals the held level.
- R6: When a status change includes a bit of an edge-mode line, `irq_o` shows the inverse of the held level for exactly one cycle and then returns to it. Edge-mode changes in the same cycle merge into one pulse.
- R7: A cycle in which the status word does not change leaves the held level unchanged and produces no pulse. This holds even if the control bytes have been rewritten.
- R8: A read of address 8+2*s+n makes `ack_o` equal to a one-hot vector with bit 2*s+n set for the cycle after the read. Otherwise `ack_o` is 0.
- R9: `timeout_i[s]` high sets the sticky status bit 8+s. A write to address 4 with bit 8+s set clears it, unless `timeout_i[s]` is high in the same cycle, in which case setting wins.
- R10: Address 4 reads the status word as follows: line bits in 7:0, timeout flags in 11:8 and zeros in 15:12. Addresses 5 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request level of line 2*s+n |
| timeout_i | input | 4 | Per-slot timeout event |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| ack_o | output | 8 | One-cycle lower-request pulse per line |
| irq_o | output | 1 | Host interrupt line |

## Verification
Status bits, timeout flags, control bytes, the held level and the edge pulse are all due at the first rising edge after the stimulus. The acknowledge pulse is also due one edge after its read, and read data is due combinationally in the cycle the address is presented. The bench drives its inputs 1 ns after a rising edge and checks read data before the next edge. It checks `irq_o` and `ack_o` 1 ns after that edge against a bench model advanced by exactly one step per edge, so a late or early output shows up as a mismatch.

// File: rtl/slot_irq_combiner.sv
module slot_irq_combiner #(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int CW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*NSLOT-1:0]         req_i,
  input  logic [NSLOT-1:0]           timeout_i,
  input  logic                       reg_we,
  input  logic                       reg_re,
  input  logic [$clog2(4*NSLOT)-1:0] reg_addr,
  input  logic [DW-1:0]              reg_wdata,
  output logic [DW-1:0]              reg_rdata,
  output logic [2*NSLOT-1:0]         ack_o,
  output logic                       irq_o
);
  localparam int NLINE    = 2 * NSLOT;
  localparam int AW       = $clog2(4 * NSLOT);
  localparam int ST_ADDR  = NSLOT;
  localparam int ACK_BASE = 2 * NSLOT;
  localparam int TO_LSB   = NLINE;

  logic [CW-1:0]    ctrl_q [NSLOT];
  logic [NLINE-1:0] req_q, st_q, st_d, chg, en_m, edge_m, ack_q;
  logic [NSLOT-1:0] to_q, to_clr;
  logic             lvl_q, pulse_q, st_moved, wr_st, rd_ack;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign en_m[2*s]     = ctrl_q[s][0];
    assign en_m[2*s+1]   = ctrl_q[s][1];
    assign edge_m[2*s]   = ctrl_q[s][2];
    assign edge_m[2*s+1] = ctrl_q[s][3];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ctrl_q[s] <= '0;
      else if (reg_we && reg_addr == AW'(s)) ctrl_q[s] <= reg_wdata[CW-1:0];

    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_st && reg_wdata[TO_LSB+s] && !timeout_i[s] |=> !to_q[s]); // R9
  end

  assign chg      = en_m & (req_i ^ req_q);
  assign st_d     = (st_q & ~chg) | (req_i & chg);
  assign st_moved = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q   <= '0;
      st_q    <= '0;
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      req_q <= req_i;
      st_q  <= st_d;
      if (st_moved) begin
        pulse_q <= |((st_d ^ st_q) & edge_m);
        lvl_q   <= |(st_d & ~edge_m);
      end else begin
        pulse_q <= 1'b0;
      end
    end

  assign irq_o = lvl_q ^ pulse_q;

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_m[i] |=> $stable(st_q[i])); // R3
    AST_ON_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      en_m[i] && (req_i[i] != req_q[i]) |=> st_q[i] == $past(req_i[i])); // R4
  end

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !st_moved |=> $stable(lvl_q) && !pulse_q); // R7

  assign wr_st  = reg_we && reg_addr == AW'(ST_ADDR);
  assign to_clr = wr_st ? reg_wdata[TO_LSB +: NSLOT] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) to_q <= '0;
    else        to_q <= (to_q & ~to_clr) | timeout_i;

  assign rd_ack = reg_re && reg_addr >= AW'(ACK_BASE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ack_q <= '0;
    else if (rd_ack) ack_q <= NLINE'(1) << (reg_addr - AW'(ACK_BASE));
    else             ack_q <= '0;

  assign ack_o = ack_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R8

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NSLOT; s++)
      if (reg_addr == AW'(s)) reg_rdata = DW'(ctrl_q[s]);
    if (reg_addr == AW'(ST_ADDR)) begin
      reg_rdata[NLINE-1:0]         = st_q;
      reg_rdata[TO_LSB +: NSLOT]   = to_q;
    end
  end
endmodule

// File: tb/slot_irq_combiner_tb.sv
module slot_irq_combiner_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  req = 0;
  logic [3:0]  tmo = 0;
  logic        we = 0, re = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [7:0]  ack;
  logic        irq;

  int checks = 0, fails = 0;

  logic [7:0] m_ctrl [4];
  logic [7:0] m_req, m_st, m_ack;
  logic [3:0] m_to;
  logic       m_lvl, m_pulse;

  slot_irq_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .timeout_i(tmo),
    .reg_we(we), .reg_re(re), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ack_o(ack), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    if (a < 4) return {8'h00, m_ctrl[a[1:0]]};
    if (a == 4) return {4'h0, m_to, m_st};
    return 16'h0000;
  endfunction

  task automatic step(input string tag);
    logic [7:0] en, edg, chg, nst, nack;
    logic [3:0] nto;
    logic       nlvl, npulse;
    #1;
    if (re) chk(rdata, exp_rd(addr), (addr < 4) ? "R2" : "R10");
    for (int s = 0; s < 4; s++) begin
      en[2*s] = m_ctrl[s][0];  en[2*s+1] = m_ctrl[s][1];
      edg[2*s] = m_ctrl[s][2]; edg[2*s+1] = m_ctrl[s][3];
    end
    chg = en & (req ^ m_req);
    nst = (m_st & ~chg) | (req & chg);
    nlvl = m_lvl; npulse = 0;
    if (nst != m_st) begin
      npulse = |((nst ^ m_st) & edg);
      nlvl   = |(nst & ~edg);
    end
    nack = (re && addr >= 8) ? (8'd1 << (addr - 4'd8)) : 8'd0;
    nto = (m_to & ~((we && addr == 4) ? wdata[11:8] : 4'h0)) | tmo;
    @(posedge clk);
    if (we && addr < 4) m_ctrl[addr[1:0]] = wdata[7:0];
    m_req = req; m_st = nst; m_lvl = nlvl; m_pulse = npulse; m_ack = nack; m_to = nto;
    #1;
    chk({15'd0, irq}, {15'd0, m_lvl ^ m_pulse}, tag);
    chk({8'd0, ack}, {8'd0, m_ack}, "R8");
    we = 0; re = 0; tmo = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    we = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    re = 1; addr = a; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 4; s++) m_ctrl[s] = 0;
    m_req = 0; m_st = 0; m_ack = 0; m_to = 0; m_lvl = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk({15'd0, irq}, 16'd0, "R1");
    addr = 4; #1 chk(rdata, 16'h0000, "R1");
    addr = 2; #1 chk(rdata, 16'h0000, "R1");
    chk({8'd0, ack}, 16'd0, "R1");
    // R2 control readback
    wr(4'd2, 16'hA55A, "R2");
    addr = 2; #1 chk(rdata, 16'h005A, "R2");
    wr(4'd2, 16'h0000, "R2");
    // R3 disabled lines ignored
    req = 8'hFF; step("R3");
    addr = 4; #1 chk(rdata, 16'h0000, "R3");
    chk({15'd0, irq}, 16'd0, "R3");
    req = 8'h00; step("R3");
    // R4, R5 level line slot1 line0
    wr(4'd1, 16'h0001, "R4");
    req[2] = 1; step("R5");
    addr = 4; #1 chk(rdata, 16'h0004, "R4");
    chk({15'd0, irq}, 16'd1, "R5");
    req[2] = 0; step("R5");
    chk({15'd0, irq}, 16'd0, "R5");
    // R6 edge line slot0 line1, pulse from low
    wr(4'd0, 16'h000A, "R6");
    req[1] = 1; step("R6");
    chk({15'd0, irq}, 16'd1, "R6");
    step("R6");
    chk({15'd0, irq}, 16'd0, "R6");
    // R6 merged pulse from high level, two edge lines same cycle
    wr(4'd3, 16'h000F, "R6");
    req[2] = 1; step("R5");
    chk({15'd0, irq}, 16'd1, "R5");
    req[7:6] = 2'b11; step("R6");
    chk({15'd0, irq}, 16'd0, "R6");
    step("R6");
    chk({15'd0, irq}, 16'd1, "R6");
    // R7 control rewrite alone leaves output
    wr(4'd1, 16'h0005, "R7");
    step("R7");
    chk({15'd0, irq}, 16'd1, "R7");
    // R8 acknowledge
    rd(4'd11, "R8");
    chk({8'd0, ack}, 16'h0008, "R8");
    step("R8");
    chk({8'd0, ack}, 16'h0000, "R8");
    rd(4'd4, "R8");
    chk({8'd0, ack}, 16'h0000, "R8");
    // R9 timeout set, clear, set wins
    tmo = 4'b0101; step("R9");
    addr = 4; #1 chk(rdata[11:8], 16'h5, "R9");
    wr(4'd4, 16'h0100, "R9");
    addr = 4; #1 chk(rdata[11:8], 16'h4, "R9");
    tmo = 4'b0100; wr(4'd4, 16'h0F00, "R9");
    addr = 4; #1 chk(rdata[11:8], 16'h4, "R9");
    // R10 unused addresses
    addr = 7; #1 chk(rdata, 16'h0000, "R10");
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 3 == 0) req[$urandom % 8] ^= 1'b1;
      if ($urandom % 12 == 0) begin
        we = 1; addr = 4'($urandom % 5); wdata = 16'($urandom);
      end else if ($urandom % 6 == 0) begin
        re = 1; addr = 4'($urandom % 16);
      end
      if ($urandom % 40 == 0) tmo = 4'($urandom);
      step("R5");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule